// File: doc/BRIEF.md
# EEPROM Word Address Counter

This block keeps the 8-bit word address of a 256-byte serial memory and advances it after every byte that is transferred. The bus protocol engine loads it from the received word-address byte. The engine pulses an increment strobe after each data byte it writes or reads. The access mode decides how far the increment carries.

In write mode only the low four bits advance. A burst of writes therefore stays inside its 16-byte page and wraps back to the start of that same page. In read mode all eight bits advance, so a long read sweeps the whole array and rolls over from 0xFF to 0x00. Because the counter always ends one past the last byte touched, a later read with no new address continues from there.

The block also flags whether the current address lies in the protected upper half of the array while the write-protect pin is high. The protocol engine uses that flag to refuse data bytes.

Top module: `eeprom_waddr_cnt`

## Requirements
- R1: While rst_ni is low, and at the first clock after it rises with no command, addr_o is 0x00.
- R2: When load_i is high at a rising clock edge, addr_o equals load_val_i after that edge.
- R3: When load_i and incr_i are both high at the same edge, the load wins and addr_o equals load_val_i.
- R4: With mode_i = 0 (write), an increment without load adds one to addr_o[3:0] and leaves addr_o[7:4] unchanged.
- R5: In write mode, an increment from page offset 0xF gives offset 0x0 in the same page. A write burst may start at any offset of the page.
- R6: With mode_i = 1 (read), an increment without load adds one to the full 8-bit address.
- R7: In read mode, an increment from 0xFF gives 0x00.
- R8: With load_i and incr_i both low, addr_o keeps its value.
- R9: prot_o is high exactly when wp_i is high and addr_o is 0x80 or above. It follows wp_i and addr_o in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the address from load_val_i |
| load_val_i | input | 8 | Received word-address byte |
| incr_i | input | 1 | Advance the address after one byte has been transferred |
| mode_i | input | 1 | 0 = write (page wrap), 1 = read (full wrap) |
| wp_i | input | 1 | Write-protect pin level |
| addr_o | output | 8 | Current word address |
| prot_o | output | 1 | Current address is in the protected region |

## Verification
The assertions assume that mode_i and the strobes are stable around each rising edge. They also assume that mode_i at an increment edge is the mode of the byte that was just transferred. The stimulus keeps to this by changing every input only on the falling clock edge. The stimulus walks the counter across page ends, across the 0x7F/0x80 protection boundary and across the 0xFF/0x00 rollover. It also toggles wp_i while the address sits on either side of the boundary.

// File: rtl/waddr_pkg.sv
package waddr_pkg;
  typedef enum logic {
    MODE_WR = 1'b0,
    MODE_RD = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/waddr_step.sv
module waddr_step #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0]  cur_i,
  input  waddr_pkg::acc_mode_e mode_i,
  output logic [ADDR_W-1:0]  nxt_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] off_inc;
  logic [ADDR_W-1:0] full_inc;

  assign off_inc  = cur_i[PAGE_W-1:0] + PAGE_W'(1);
  assign full_inc = cur_i + ADDR_W'(1);

  always_comb begin
    if (mode_i == waddr_pkg::MODE_RD) nxt_o = full_inc;
    else                              nxt_o = {cur_i[ADDR_W-1 -: HI_W], off_inc};
  end
endmodule

// File: rtl/waddr_guard.sv
module waddr_guard #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  output logic              prot_o
);
  // protected region is the upper half of the array
  assign prot_o = wp_i & addr_i[ADDR_W-1];
endmodule

// File: rtl/eeprom_waddr_cnt.sv
module eeprom_waddr_cnt #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              incr_i,
  input  logic              mode_i,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              prot_o
);
  import waddr_pkg::*;

  localparam logic [PAGE_W-1:0] OFF_LAST = '1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);

  acc_mode_e         mode;
  logic [ADDR_W-1:0] addr_q, step_nxt;

  assign mode = acc_mode_e'(mode_i);

  waddr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) step_i (
    .cur_i (addr_q),
    .mode_i(mode),
    .nxt_o (step_nxt)
  );

  waddr_guard #(.ADDR_W(ADDR_W)) guard_i (
    .addr_i(addr_q),
    .wp_i  (wp_i),
    .prot_o(prot_o)
  );

  // load has priority over increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (incr_i) addr_q <= step_nxt;
  end

  assign addr_o = addr_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_val_i));

  assert_load_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && incr_i) |=> addr_o == $past(load_val_i));

  assert_wr_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && mode_i == 1'b0) |=>
      (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W])) &&
      (addr_o[PAGE_W-1:0] == $past(addr_o[PAGE_W-1:0]) + PAGE_W'(1)));

  assert_wr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && mode_i == 1'b0 && addr_o[PAGE_W-1:0] == OFF_LAST) |=>
      addr_o[PAGE_W-1:0] == '0);

  assert_rd_incr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && mode_i == 1'b1) |=> addr_o == $past(addr_o) + ADDR_W'(1));

  assert_rd_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !load_i && mode_i == 1'b1 && addr_o == ADDR_LAST) |=> addr_o == '0);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!incr_i && !load_i) |=> $stable(addr_o));

  assert_prot_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_i || addr_o < HALF) |-> !prot_o);

  assert_prot_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && addr_o >= HALF) |-> prot_o);
endmodule

// File: tb/eeprom_waddr_cnt_tb_top.sv
module eeprom_waddr_cnt_tb_top;
  typedef struct {
    logic [7:0] addr;
    logic       prot;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_val = '0;
  logic       incr = 1'b0;
  logic       mode = 1'b0;
  logic       wp = 1'b0;
  logic [7:0] addr;
  logic       prot;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  logic [7:0] m_addr = '0;

  always #10 clk = ~clk;

  eeprom_waddr_cnt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_val_i(load_val),
    .incr_i(incr), .mode_i(mode), .wp_i(wp), .addr_o(addr), .prot_o(prot)
  );

  task automatic op(input logic ld, input logic [7:0] v, input logic inc,
                    input logic rd, input logic w, input string req);
    exp_t e;
    @(negedge clk);
    load = ld; load_val = v; incr = inc; mode = rd; wp = w;
    if (ld)       m_addr = v;
    else if (inc) m_addr = rd ? m_addr + 8'd1 : {m_addr[7:4], m_addr[3:0] + 4'd1};
    e.addr = m_addr;
    e.prot = w && (m_addr >= 8'h80);
    e.req  = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (addr !== e.addr || prot !== e.prot) begin
          fails++;
          $display("FAIL %s: addr=%02h prot=%0b expected addr=%02h prot=%0b",
                   e.req, addr, prot, e.addr, e.prot);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #25;
    checks++;
    if (addr !== 8'h00) begin
      fails++;
      $display("FAIL R1: addr=%02h expected addr=00", addr);
    end
    @(negedge clk);
    rst_n = 1'b1;
    op(0, 8'h00, 0, 0, 0, "R1");
    op(1, 8'h3D, 0, 0, 0, "R2");
    op(0, 8'h00, 1, 0, 0, "R4");
    op(0, 8'h00, 1, 0, 0, "R4");
    op(0, 8'h00, 1, 0, 0, "R5");
    op(0, 8'h00, 1, 0, 0, "R4");
    op(1, 8'h7E, 1, 0, 0, "R3");
    op(1, 8'h11, 1, 1, 0, "R3");
    op(1, 8'h7E, 0, 0, 0, "R2");
    op(0, 8'h00, 1, 1, 0, "R6");
    op(0, 8'h00, 1, 1, 1, "R6");
    op(0, 8'h00, 0, 1, 1, "R9");
    op(0, 8'h00, 0, 1, 0, "R9");
    op(0, 8'h00, 0, 1, 1, "R8");
    op(1, 8'hFE, 0, 1, 0, "R2");
    op(0, 8'h00, 1, 1, 0, "R6");
    op(0, 8'h00, 1, 1, 0, "R7");
    op(0, 8'h00, 0, 0, 1, "R9");
    op(1, 8'hF9, 0, 0, 1, "R9");
    for (int i = 0; i < 8; i++) op(0, 8'h00, 1, 0, 1, "R5");
    op(0, 8'h00, 0, 0, 1, "R8");
    op(0, 8'h00, 1, 1, 1, "R6");
    op(1, 8'h8F, 0, 0, 0, "R2");
    op(0, 8'h00, 1, 0, 1, "R5");
    op(0, 8'h00, 1, 1, 1, "R6");
    op(1, 8'h7F, 0, 1, 1, "R9");
    op(0, 8'h00, 1, 1, 1, "R9");
    @(negedge clk);
    load = 1'b0; incr = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule